// File: doc/BRIEF.md
# Frame Transmit Handshake for a Serial Storage Link

This block drives the transmit side of the link layer at one end of a point-to-point serial storage link. It chooses one 32-bit word per clock for the encoder: a primitive code or a data DWORD. At rest it sends the idle primitive. When the upper layer asks to send a frame, it announces the frame and waits for the far end to grant it. It then sends the start delimiter, the payload from a show-ahead FIFO, an externally computed CRC word and the end delimiter. Finally it waits for the far end's verdict.

The receive path supplies one decoded primitive code per clock. The block remembers the last real primitive, so a continuation primitive, or the unrecognised words that follow it, stands for "the same as before". If the payload FIFO runs dry mid-frame, the block fills the gap with the hold primitive. A parameter selects the host role, which gives way when both ends announce at once, or the device role, which keeps announcing.

Top module: `frame_tx_link`

## Requirements
- R1: Primitive codes on `rx_prim` and `tx_code` are 4 bits: 0 data/none, 1 SYNC, 2 X_RDY, 3 R_RDY, 4 SOF, 5 EOF, 6 HOLD, 7 HOLDA, 8 WTRM, 9 R_IP, 10 R_OK, 11 R_ERR, 12 CONT. During reset and while no frame is requested, `tx_code` is SYNC, `fifo_pop` is 0 and both verdict pulses are 0.
- R2: A frame request seen at a clock edge while idle makes `tx_code` X_RDY from that edge on. X_RDY repeats until the far end's effective primitive is R_RDY.
- R3: At the edge where the effective primitive is R_RDY while X_RDY is being sent, SOF is sent. Each payload word follows in FIFO order with `tx_code` 0. After the word flagged `fifo_last`, `crc_dw` is sent with `tx_code` 0, and EOF follows on the next cycle.
- R4: During the payload, the word sent at an edge where `fifo_empty` is high is HOLD. The next FIFO word is sent at the first edge where `fifo_empty` is low. `fifo_pop` is high exactly when a payload word is taken at the coming edge.
- R5: After EOF, WTRM is sent every cycle until R_OK or R_ERR is the effective primitive.
- R6: When R_OK is the effective primitive while WTRM is being sent, SYNC is sent at that edge. `frame_ok` is high for exactly that one cycle.
- R7: When R_ERR is the effective primitive while WTRM is being sent, SYNC is sent at that edge. `frame_err` is high for that one cycle and `frame_ok` stays low.
- R8: A CONT code or code 0 on `rx_prim` counts as the last non-CONT primitive received. For example, R_RDY followed by CONT grants the frame.
- R9: With `IS_HOST`=1, receiving X_RDY while sending X_RDY switches the output to R_RDY and raises `rx_mode`. Both persist until SYNC is received, and then the block returns to idle.
- R10: With `IS_HOST`=0, receiving X_RDY while sending X_RDY leaves the output at X_RDY. Only R_RDY moves it on to SOF.
- R11: HOLD is never sent before SOF or after EOF, and `fifo_pop` is never high outside the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_req | input | 1 | Upper layer has a frame to send |
| rx_prim | input | 4 | Decoded primitive code from the receive path |
| fifo_empty | input | 1 | Payload FIFO has no word ready |
| fifo_data | input | 32 | Head word of the payload FIFO |
| fifo_last | input | 1 | Head word is the last of the frame |
| crc_dw | input | 32 | CRC DWORD sent after the payload |
| fifo_pop | output | 1 | Head word is consumed at the next edge |
| tx_code | output | 4 | Primitive to send, 0 for a data word |
| tx_data | output | 32 | Data word when `tx_code` is 0 |
| frame_ok | output | 1 | One-cycle pulse on a good verdict |
| frame_err | output | 1 | One-cycle pulse on an error verdict |
| rx_mode | output | 1 | Block gave way and acts as receiver |

## Verification
Two decisions can land on the same edge: choosing between data and HOLD, and leaving the payload for the CRC word. This happens when the last payload word appears right after a run of holds. Random FIFO emptiness on frames of one to twelve words provokes it repeatedly, and a directed one-word frame opens with holds. For every cycle, the bench predicts the output from the `fifo_empty` value it drove before that edge and its own payload index. It judges the HOLD/data choice, the word value, the single CRC word and the EOF that follows.

// File: rtl/frame_tx_link.sv
module frame_tx_link #(
  parameter bit IS_HOST = 1'b1,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_req,
  input  logic [3:0]    rx_prim,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_last,
  input  logic [DW-1:0] crc_dw,
  output logic          fifo_pop,
  output logic [3:0]    tx_code,
  output logic [DW-1:0] tx_data,
  output logic          frame_ok,
  output logic          frame_err,
  output logic          rx_mode
);
  localparam logic [3:0] C_DATA = 4'd0, C_SYNC = 4'd1, C_XRDY = 4'd2, C_RRDY = 4'd3,
                         C_SOF = 4'd4, C_EOF = 4'd5, C_HOLD = 4'd6, C_WTRM = 4'd8,
                         C_ROK = 4'd10, C_RERR = 4'd11, C_CONT = 4'd12;

  typedef enum logic [2:0] {S_IDLE, S_ANN, S_PAY, S_CRC, S_END, S_WAIT, S_RCV} st_t;
  st_t st;

  logic [3:0] held, eff;
  wire real_prim = (rx_prim != C_DATA) && (rx_prim != C_CONT);
  assign eff      = real_prim ? rx_prim : held;
  assign fifo_pop = (st == S_PAY) && !fifo_empty;
  assign rx_mode  = (st == S_RCV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      held      <= C_SYNC;
      tx_code   <= C_SYNC;
      tx_data   <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      held      <= eff;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      tx_data   <= '0;
      unique case (st)
        S_IDLE: begin
          tx_code <= frame_req ? C_XRDY : C_SYNC;
          if (frame_req) st <= S_ANN;
        end
        S_ANN: begin
          if (eff == C_RRDY) begin
            tx_code <= C_SOF;
            st      <= S_PAY;
          end else if (IS_HOST && eff == C_XRDY) begin
            tx_code <= C_RRDY;
            st      <= S_RCV;
          end else begin
            tx_code <= C_XRDY;
          end
        end
        S_PAY: begin
          if (fifo_empty) begin
            tx_code <= C_HOLD;
          end else begin
            tx_code <= C_DATA;
            tx_data <= fifo_data;
            if (fifo_last) st <= S_CRC;
          end
        end
        S_CRC: begin
          tx_code <= C_DATA;
          tx_data <= crc_dw;
          st      <= S_END;
        end
        S_END: begin
          tx_code <= C_EOF;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (eff == C_ROK || eff == C_RERR) begin
            tx_code   <= C_SYNC;
            frame_ok  <= (eff == C_ROK);
            frame_err <= (eff == C_RERR);
            st        <= S_IDLE;
          end else begin
            tx_code <= C_WTRM;
          end
        end
        S_RCV: begin
          if (eff == C_SYNC) begin
            tx_code <= C_SYNC;
            st      <= S_IDLE;
          end else begin
            tx_code <= C_RRDY;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pop_needs_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  p_hold_only_in_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == C_HOLD) |-> (st == S_PAY));
  p_sof_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == C_SOF) |-> ($past(tx_code) == C_XRDY && $past(eff) == C_RRDY));
  p_wtrm_after_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_code) == C_EOF) |-> (tx_code == C_WTRM || tx_code == C_SYNC));
  p_ok_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);
  p_verdict_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));
  p_yield_sends_rrdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode |-> (tx_code == C_RRDY));
  p_device_keeps_role_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_HOST || !rx_mode));
endmodule

// File: tb/frame_tx_link_tb.sv
module frame_tx_link_tb;
  localparam logic [3:0] C_DATA = 4'd0, C_SYNC = 4'd1, C_XRDY = 4'd2, C_RRDY = 4'd3,
                         C_SOF = 4'd4, C_EOF = 4'd5, C_HOLD = 4'd6, C_WTRM = 4'd8,
                         C_RIP = 4'd9, C_ROK = 4'd10, C_RERR = 4'd11, C_CONT = 4'd12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic frame_req = 1'b0, fifo_empty = 1'b1, fifo_last = 1'b0;
  logic [3:0] rx_prim = C_SYNC;
  logic [31:0] fifo_data = '0, crc_dw = '0;
  logic fifo_pop, frame_ok, frame_err, rx_mode;
  logic [3:0] tx_code;
  logic [31:0] tx_data;

  logic d_req = 1'b0;
  logic [3:0] d_rx = C_SYNC;
  logic d_pop, d_ok, d_err, d_rxm;
  logic [3:0] d_code;
  logic [31:0] d_data;

  frame_tx_link #(.IS_HOST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .rx_prim(rx_prim),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .crc_dw(crc_dw), .fifo_pop(fifo_pop), .tx_code(tx_code), .tx_data(tx_data),
    .frame_ok(frame_ok), .frame_err(frame_err), .rx_mode(rx_mode));

  frame_tx_link #(.IS_HOST(1'b0)) u_dev (
    .clk(clk), .rst_n(rst_n), .frame_req(d_req), .rx_prim(d_rx),
    .fifo_empty(1'b1), .fifo_data(32'h0), .fifo_last(1'b0),
    .crc_dw(32'h0), .fifo_pop(d_pop), .tx_code(d_code), .tx_data(d_data),
    .frame_ok(d_ok), .frame_err(d_err), .rx_mode(d_rxm));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic bit is_empty(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic run_frame(input int n, input int pct, input bit err, input bit cont_mode, input bit lead_hold);
    logic [31:0] pl [16];
    int idx;
    bit emp;
    for (int i = 0; i < n; i++) pl[i] = $urandom;
    frame_req = 1'b1;
    rx_prim = cont_mode ? C_RRDY : C_SYNC;
    tick();
    chk(tx_code == C_XRDY, "R2", tx_code, C_XRDY);
    frame_req = 1'b0;
    if (cont_mode) begin
      rx_prim = C_CONT;
      tick();
      chk(tx_code == C_SOF, "R8", tx_code, C_SOF);
    end else begin
      repeat ($urandom % 4) begin
        rx_prim = ($urandom % 2) ? C_DATA : C_RIP;
        tick();
        chk(tx_code == C_XRDY, "R2", tx_code, C_XRDY);
      end
      rx_prim = C_RRDY;
      tick();
      chk(tx_code == C_SOF, "R3", tx_code, C_SOF);
    end
    rx_prim = cont_mode ? C_CONT : C_RIP;
    idx = 0;
    while (idx < n) begin
      emp = lead_hold ? 1'b1 : is_empty(pct);
      lead_hold = 1'b0;
      fifo_empty = emp;
      fifo_data = emp ? 32'hDEAD_0000 : pl[idx];
      fifo_last = (idx == n - 1);
      #1;
      chk(fifo_pop == !emp, "R4", fifo_pop, !emp);
      tick();
      if (emp) begin
        chk(tx_code == C_HOLD, "R4", tx_code, C_HOLD);
      end else begin
        chk(tx_code == C_DATA && tx_data == pl[idx], "R3", tx_data, pl[idx]);
        idx++;
      end
    end
    fifo_empty = is_empty(50);
    fifo_last = 1'b0;
    crc_dw = $urandom;
    #1;
    chk(fifo_pop == 1'b0, "R11", fifo_pop, 0);
    tick();
    chk(tx_code == C_DATA && tx_data == crc_dw, "R3", tx_data, crc_dw);
    tick();
    chk(tx_code == C_EOF, "R3", tx_code, C_EOF);
    chk(fifo_pop == 1'b0, "R11", fifo_pop, 0);
    repeat (1 + $urandom % 3) begin
      rx_prim = ($urandom % 2) ? C_CONT : C_RIP;
      tick();
      chk(tx_code == C_WTRM, "R5", tx_code, C_WTRM);
    end
    rx_prim = err ? C_RERR : C_ROK;
    tick();
    chk(tx_code == C_SYNC, err ? "R7" : "R6", tx_code, C_SYNC);
    chk(frame_ok == !err, "R6", frame_ok, !err);
    chk(frame_err == err, "R7", frame_err, err);
    rx_prim = C_SYNC;
    fifo_empty = 1'b1;
    tick();
    chk(tx_code == C_SYNC && !frame_ok && !frame_err, "R6", {tx_code, frame_ok, frame_err}, {C_SYNC, 2'b00});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(tx_code == C_SYNC && !fifo_pop && !frame_ok && !frame_err, "R1", tx_code, C_SYNC);
    rst_n = 1'b1;
    repeat (2) begin
      tick();
      chk(tx_code == C_SYNC && !fifo_pop, "R1", tx_code, C_SYNC);
    end

    run_frame(1, 0, 1'b0, 1'b0, 1'b1);
    run_frame(4, 0, 1'b0, 1'b0, 1'b0);
    run_frame(3, 50, 1'b1, 1'b0, 1'b0);
    run_frame(2, 30, 1'b0, 1'b1, 1'b0);
    for (int f = 0; f < 20; f++)
      run_frame(1 + $urandom % 12, $urandom % 80, f[0], f[2], f[3]);

    frame_req = 1'b1;
    rx_prim = C_XRDY;
    d_req = 1'b1;
    d_rx = C_XRDY;
    tick();
    chk(tx_code == C_XRDY, "R2", tx_code, C_XRDY);
    chk(d_code == C_XRDY, "R10", d_code, C_XRDY);
    frame_req = 1'b0;
    d_req = 1'b0;
    tick();
    chk(tx_code == C_RRDY && rx_mode, "R9", {tx_code, rx_mode}, {C_RRDY, 1'b1});
    chk(d_code == C_XRDY && !d_rxm, "R10", d_code, C_XRDY);
    rx_prim = C_CONT;
    tick();
    chk(tx_code == C_RRDY && rx_mode, "R9", {tx_code, rx_mode}, {C_RRDY, 1'b1});
    chk(d_code == C_XRDY, "R10", d_code, C_XRDY);
    rx_prim = C_SYNC;
    d_rx = C_RRDY;
    tick();
    chk(tx_code == C_SYNC && !rx_mode, "R9", {tx_code, rx_mode}, {C_SYNC, 1'b0});
    chk(d_code == C_SOF, "R10", d_code, C_SOF);
    tick();
    chk(tx_code == C_SYNC, "R1", tx_code, C_SYNC);
    chk(d_code == C_HOLD, "R4", d_code, C_HOLD);

    finish_run();
  end
endmodule